// File: doc/BRIEF.md
# Interleaved/Linear Burst Address Generator

This block produces the low-order address bits of a four-beat burst for a synchronous burst memory. When a burst is opened, a load strobe captures the two low address bits as the starting point. From then on, each clock edge where the advance input is high moves to the next beat. When advance is low and no load is present, the burst pauses on its current beat.

The visiting order is selected by a static mode input. With mode high the order is interleaved: the address is the start value XOR the beat count. With mode low the order is linear: the address is the start value plus the beat count, wrapping modulo four. There is no burst-end condition, so advancing past the fourth beat repeats the same pattern.

The output carries only the low bits. Logic outside this block joins them with the registered upper address. The mode input is registered, so a change of mode shows on the output one cycle after it is sampled.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset the output `addr_lo_o` is 00 and the registered order is linear (as if mode were 0).
- R2: On an edge with `load_i` = 1, the value of `start_lo_i` becomes the beat-0 address, and it appears on `addr_lo_o` after that edge. `advance_i` has no effect on a load edge.
- R3: With the registered mode = 1 (interleaved), beat n of start s outputs s XOR n. For example, start 01 gives 01,00,11,10, start 10 gives 10,11,00,01, and start 11 gives 11,10,01,00.
- R4: With the registered mode = 0 (linear), beat n of start s outputs (s + n) mod 4. For example, start 01 gives 01,10,11,00 and start 11 gives 11,00,01,10.
- R5: On an edge with `load_i` = 0 and `advance_i` = 0, the beat is held (suspend). If the mode is also unchanged, `addr_lo_o` is unchanged.
- R6: Advancing past the fourth beat wraps the beat count to 0 and repeats the same order. No flag stops the counter.
- R7: `order_sel_i` is sampled on every clock edge. The output follows the mode sampled at the most recent edge, so a change takes effect one cycle later, and the current beat and start are kept.
- R8: A load in the middle of a burst discards the current beat and restarts at beat 0 with the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Burst open: capture the start bits (an accepted address strobe) |
| start_lo_i | input | BEAT_W | Low-order address bits that form the burst start |
| advance_i | input | 1 | High: step to the next beat on this edge |
| order_sel_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_lo_o | output | BEAT_W | Current low-order burst address |

## Verification
The embedded assertions check four things on every clock:
- a load places the captured start on the output;
- a suspend with a stable mode leaves the address unchanged;
- a linear advance adds exactly one;
- the first interleaved advance flips only bit 0.

The full visiting orders for every start value, wrap-around beyond four beats, the one-cycle delay of a mode change in the middle of a burst, and a reload in the middle of a burst depend on multi-cycle history. Only the bench scenarios, checked cycle by cycle against an independent model, can show these.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Burst visiting order selected by the static mode input
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    localparam int unsigned DEF_BEAT_W = 2;

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   order_sel_i,
    output order_e order_q_o
);

    order_e order_d;
    order_e order_q;

    always_comb begin
        order_d = order_e'(order_sel_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            order_q <= ORD_LINEAR;
        end else begin
            order_q <= order_d;
        end
    end

    assign order_q_o = order_q;

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int unsigned BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BEAT_W-1:0] start_lo_i,
    input  logic              advance_i,
    output logic [BEAT_W-1:0] start_q_o,
    output logic [BEAT_W-1:0] beat_q_o
);

    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    typedef struct packed {
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
    } ctr_s;

    ctr_s st_d;
    ctr_s st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.start = start_lo_i;
            st_d.beat  = '0;
        end else if (advance_i) begin
            st_d.beat = st_q.beat + BEAT_ONE;   // natural wrap, no end flag
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_q_o = st_q.start;
    assign beat_q_o  = st_q.beat;

    // R8
    reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (beat_q_o == '0));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int unsigned BEAT_W = 2
) (
    input  order_e            order_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [BEAT_W-1:0] addr_o
);

    logic [BEAT_W-1:0] lin_addr;
    logic [BEAT_W-1:0] ilv_addr;

    always_comb begin
        lin_addr = start_i + beat_i;
        ilv_addr = start_i ^ beat_i;
        addr_o   = (order_i == ORD_INTERLEAVE) ? ilv_addr : lin_addr;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int unsigned BEAT_W = DEF_BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BEAT_W-1:0] start_lo_i,
    input  logic              advance_i,
    input  logic              order_sel_i,
    output logic [BEAT_W-1:0] addr_lo_o
);

    localparam logic [BEAT_W-1:0] ONE_LSB = BEAT_W'(1);

    order_e            order_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;

    burst_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .order_sel_i (order_sel_i),
        .order_q_o   (order_q)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .start_lo_i (start_lo_i),
        .advance_i  (advance_i),
        .start_q_o  (start_q),
        .beat_q_o   (beat_q)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .order_i (order_q),
        .start_i (start_q),
        .beat_i  (beat_q),
        .addr_o  (addr_lo_o)
    );

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_lo_o == $past(start_lo_i)));

    // R5
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !advance_i && (order_e'(order_sel_i) == order_q))
        |=> $stable(addr_lo_o));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && advance_i && order_q == ORD_LINEAR && !order_sel_i)
        |=> (addr_lo_o == $past(addr_lo_o) + ONE_LSB));

    // R3
    interleave_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && advance_i && beat_q == '0 &&
         order_q == ORD_INTERLEAVE && order_sel_i)
        |=> (addr_lo_o == ($past(addr_lo_o) ^ ONE_LSB)));

endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] start_lo_i = '0;
    logic         advance_i = 1'b0;
    logic         order_sel_i = 1'b0;
    logic [W-1:0] addr_lo_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    // independent reference model
    logic [W-1:0] m_start = '0;
    logic [W-1:0] m_beat  = '0;
    logic         m_mode  = 1'b0;

    burst_addr_gen #(.BEAT_W(W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .start_lo_i  (start_lo_i),
        .advance_i   (advance_i),
        .order_sel_i (order_sel_i),
        .addr_lo_o   (addr_lo_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [W-1:0] model_addr();
        return m_mode ? (m_start ^ m_beat) : (m_start + m_beat);
    endfunction

    task automatic step(input logic ld, input logic [W-1:0] a,
                        input logic adv, input logic md, input string tag);
        @(negedge clk);
        load_i      = ld;
        start_lo_i  = a;
        advance_i   = adv;
        order_sel_i = md;
        @(posedge clk);
        #1;
        m_mode = md;
        if (ld) begin
            m_start = a;
            m_beat  = '0;
        end else if (adv) begin
            m_beat = m_beat + 1'b1;
        end
        exp_q.push_back(model_addr());
        tag_q.push_back(tag);
    endtask

    // monitor: compares one expected item per cycle, away from the edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (addr_lo_o !== e) begin
                n_bad++;
                $display("FAIL %s: addr_lo_o=%b expected %b", t, addr_lo_o, e);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (addr_lo_o !== 2'b00) begin
            n_bad++;
            $display("FAIL R1: addr_lo_o=%b expected 00", addr_lo_o);
        end
        rst_n = 1'b1;

        // R2 load with advance high is ignored; R3 interleaved, start 01
        step(1, 2'b01, 1, 1, "R2");
        step(0, 2'b00, 1, 1, "R3");
        step(0, 2'b00, 1, 1, "R3");
        step(0, 2'b00, 1, 1, "R3");
        // R6 wrap past fourth beat
        step(0, 2'b00, 1, 1, "R6");
        step(0, 2'b00, 1, 1, "R6");
        // R3 start 10 and start 11
        step(1, 2'b10, 0, 1, "R3");
        for (int i = 0; i < 3; i++) step(0, 2'b00, 1, 1, "R3");
        step(1, 2'b11, 0, 1, "R3");
        for (int i = 0; i < 3; i++) step(0, 2'b00, 1, 1, "R3");

        // R4 linear start 01, then R6 wrap
        step(1, 2'b01, 0, 0, "R4");
        for (int i = 0; i < 3; i++) step(0, 2'b00, 1, 0, "R4");
        step(0, 2'b00, 1, 0, "R6");
        // R4 start 11 with R5 suspend in the middle
        step(1, 2'b11, 0, 0, "R4");
        step(0, 2'b00, 1, 0, "R4");
        step(0, 2'b10, 0, 0, "R5");
        step(0, 2'b01, 0, 0, "R5");
        step(0, 2'b00, 1, 0, "R4");
        step(0, 2'b00, 1, 0, "R4");

        // R7 mode change in the middle of a burst takes effect after the next edge
        step(1, 2'b01, 0, 0, "R7");
        step(0, 2'b00, 1, 0, "R7");
        step(0, 2'b00, 0, 1, "R7");
        step(0, 2'b00, 1, 0, "R7");
        step(0, 2'b00, 1, 1, "R7");

        // R8 reload in the middle of a burst
        step(1, 2'b00, 0, 0, "R8");
        step(0, 2'b00, 1, 0, "R8");
        step(1, 2'b10, 1, 0, "R8");
        step(0, 2'b00, 1, 0, "R8");

        @(negedge clk);
        load_i    = 1'b0;
        advance_i = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule